// File: doc/BRIEF.md
# Banked per-CPU interrupt aggregator

This block gathers a set of level-sensitive interrupt sources, 32 per register word, and drives one interrupt line to each of several CPUs. Every CPU owns a private register window on a simple 32-bit memory-mapped bus. Within its window a CPU programs its own enable mask. It can also read a status view of the source levels, which is common to all windows. A CPU's line is raised while at least one source is both active and enabled in that CPU's window.

Software gives a source to a CPU by setting the source's bit in that CPU's enable word with a full-word write. Set/clear aliases do not exist. A CPU's enables never route a source to a different CPU. Word order inside each window is reversed: the lowest word address serves the highest-numbered sources.

Top module: `irq_bank_aggr`

## Requirements
- R1: After reset every enable word reads as zero and every bit of `irq_out` is 0.
- R2: Let N be `N_WORDS`. Within a window, enable word i sits at byte offset 4*i and status word i sits at byte offset 4*(N+i). Word i covers sources 32*(N-1-i)+b, where b is the bit position in the word. With N=2, offset 0x00 is the enable word for sources 63..32 and offset 0x04 is the enable word for sources 31..0. Offset 0x08 is the status word for sources 63..32 and offset 0x0C is the status word for sources 31..0.
- R3: The window of CPU c begins at byte address c*8*N, directly after the last status word of CPU c-1.
- R4: An enable word accepts a full 32-bit write and then reads back the value written. No other register changes.
- R5: Status words are read-only. They show the level of each source after a two-flop synchronizer, and a write to a status offset changes nothing.
- R6: A status word reads the same value through the window of every CPU.
- R7: `irq_out[c]` is a register. It is 1 when the bitwise AND of the synchronized sources and CPU c's enables is non-zero. It changes on the clock edge after an enable write is captured, and on the third edge after a source input changes.
- R8: A read of an address beyond the last window, or of an address whose two low bits are not zero, returns zero. A write to such an address is ignored.
- R9: Read data is registered. It is valid in the cycle after `rd_en` and holds until the next read. A read and a write to the same address in one cycle return the value from before the write.
- R10: Each CPU's enables are independent. Writing one CPU's enable word leaves the other CPU's enables and interrupt line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src | input | 32*N_WORDS | Interrupt source levels; bit k is source k |
| wr_en | input | 1 | Write strobe, one cycle per word |
| rd_en | input | 1 | Read strobe, one cycle per word |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_out | output | N_CPU | Interrupt line for each CPU |

## Verification
Two collisions matter here. In the first, a source's synchronized level reaches the status view on the same clock edge that an enable write for that source is captured. The bench starts the write one cycle after the source changes, so the two land on the same edge. It then requires `irq_out` to stay low for one more cycle and rise on the following edge. In the second, a read and a write hit the same enable word in one cycle. The bench drives both strobes together and requires the returned data to be the old value and a later read to show the new one.

// File: rtl/irq_bank_aggr.sv
module irq_bank_aggr #(
  parameter int N_CPU   = 2,
  parameter int N_WORDS = 2,
  parameter int ADDR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [32*N_WORDS-1:0] src,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [N_CPU-1:0]      irq_out
);
  localparam int SRC_W     = 32 * N_WORDS;
  localparam int WIN_WORDS = 2 * N_WORDS;
  localparam int MAP_WORDS = N_CPU * WIN_WORDS;

  logic [SRC_W-1:0] sync1_q, sync2_q;
  logic [31:0]      en_q    [N_CPU][N_WORDS];
  logic [31:0]      st_word [N_WORDS];
  logic [N_WORDS-1:0] en_hit [N_CPU];
  logic [N_CPU-1:0] pend;
  logic [31:0]      rd_mux;
  logic             aligned, mapped, is_st;
  int unsigned      wi, cpu_i, slot_i, word_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= src;
      sync2_q <= sync1_q;
    end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_st
    assign st_word[i] = sync2_q[(N_WORDS-1-i)*32 +: 32];
  end

  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    wi     = 32'(addr[ADDR_W-1:2]);
    cpu_i  = wi / WIN_WORDS;
    slot_i = wi % WIN_WORDS;
    mapped = aligned && (wi < MAP_WORDS);
    is_st  = mapped && (slot_i >= N_WORDS);
    word_i = is_st ? slot_i - N_WORDS : slot_i;
    for (int c = 0; c < N_CPU; c++)
      for (int i = 0; i < N_WORDS; i++)
        en_hit[c][i] = mapped && !is_st && (cpu_i == c) && (word_i == i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int c = 0; c < N_CPU; c++)
        for (int i = 0; i < N_WORDS; i++)
          en_q[c][i] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < N_CPU; c++)
        for (int i = 0; i < N_WORDS; i++)
          if (en_hit[c][i]) en_q[c][i] <= wdata;
    end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < N_CPU; c++)
      for (int i = 0; i < N_WORDS; i++)
        if (en_hit[c][i]) rd_mux = en_q[c][i];
    for (int i = 0; i < N_WORDS; i++)
      if (is_st && word_i == i) rd_mux = st_word[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;

  always_comb
    for (int c = 0; c < N_CPU; c++) begin
      pend[c] = 1'b0;
      for (int i = 0; i < N_WORDS; i++)
        pend[c] = pend[c] | (|(en_q[c][i] & st_word[i]));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_out <= '0;
    else        irq_out <= pend;

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == 32'd0));

  p_status_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync2_q == $past(sync1_q)));

  for (genvar c = 0; c < N_CPU; c++) begin : g_chk
    p_quiet_when_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] == 1'b0) |=> !irq_out[c]);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_w
      p_enable_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && en_hit[c][i]) |=> (en_q[c][i] == $past(wdata)));
      p_status_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !en_hit[c][i]) |=> $stable(en_q[c][i]));
    end
  end
endmodule

// File: tb/irq_bank_aggr_tb.sv
`timescale 1ns/1ps
module irq_bank_aggr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_out;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_bank_aggr #(.N_CPU(2), .N_WORDS(2), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, 64'(d), 64'(exp));
  endtask

  task automatic t_reset;
    chk(irq_out == 2'b00, "R1 irq after reset", 64'(irq_out), 0);
    rd_chk(8'h00, 0, "R1 cpu0 en w0");
    rd_chk(8'h04, 0, "R1 cpu0 en w1");
    rd_chk(8'h10, 0, "R1 cpu1 en w0");
    rd_chk(8'h14, 0, "R1 cpu1 en w1");
  endtask

  task automatic t_enable_rw;
    wr(8'h00, 32'hA5A5_0001);
    wr(8'h14, 32'h1234_5678);
    rd_chk(8'h00, 32'hA5A5_0001, "R4 cpu0 en w0 readback");
    rd_chk(8'h14, 32'h1234_5678, "R4 cpu1 en w1 readback");
    rd_chk(8'h04, 0, "R10 cpu0 en w1 untouched");
    rd_chk(8'h10, 0, "R3 cpu1 en w0 untouched");
    wr(8'h00, 0);
    wr(8'h14, 0);
  endtask

  task automatic t_status;
    src = 64'hDEAD_BEEF_0BAD_F00D;
    cyc(3);
    rd_chk(8'h08, 32'hDEAD_BEEF, "R2 cpu0 status w0 high sources");
    rd_chk(8'h0C, 32'h0BAD_F00D, "R2 cpu0 status w1 low sources");
    rd_chk(8'h18, 32'hDEAD_BEEF, "R6 cpu1 status w0");
    rd_chk(8'h1C, 32'h0BAD_F00D, "R6 cpu1 status w1");
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0000_0000);
    rd_chk(8'h08, 32'hDEAD_BEEF, "R5 status write ignored");
    rd_chk(8'h1C, 32'h0BAD_F00D, "R5 status write ignored cpu1");
    rd_chk(8'h00, 0, "R5 enable untouched by status write");
    chk(irq_out == 2'b00, "R5 no irq from status write", 64'(irq_out), 0);
    src = '0;
    cyc(3);
  endtask

  task automatic t_route;
    src = 64'h1 << 40;
    cyc(3);
    wr(8'h00, 32'h1 << 8);
    chk(irq_out == 2'b00, "R7 irq not yet after enable write", 64'(irq_out), 0);
    cyc(1);
    chk(irq_out == 2'b01, "R7 cpu0 irq one cycle after enable", 64'(irq_out), 1);
    chk(irq_out[1] == 1'b0, "R10 cpu1 not routed", 64'(irq_out[1]), 0);
    wr(8'h10, 32'h1 << 8);
    cyc(1);
    chk(irq_out == 2'b11, "R7 both cpus", 64'(irq_out), 3);
    src = '0;
    cyc(2);
    chk(irq_out == 2'b11, "R7 irq held two cycles after drop", 64'(irq_out), 3);
    cyc(1);
    chk(irq_out == 2'b00, "R7 irq drops third edge", 64'(irq_out), 0);
    wr(8'h00, 0);
    wr(8'h10, 0);
  endtask

  task automatic t_collide;
    src = 64'h8;
    cyc(1);
    wr(8'h04, 32'h8);
    chk(irq_out == 2'b00, "R7 same-edge enable and sync", 64'(irq_out), 0);
    cyc(1);
    chk(irq_out == 2'b01, "R7 collision irq rises", 64'(irq_out), 1);
    wr(8'h04, 0);
    src = '0;
    cyc(3);
  endtask

  task automatic t_rw_same;
    logic [31:0] d;
    wr(8'h14, 32'h55);
    addr = 8'h14; wdata = 32'hAA; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; d = rdata;
    chk(d == 32'h55, "R9 same-cycle read returns old", 64'(d), 64'h55);
    cyc(2);
    chk(rdata == 32'h55, "R9 rdata holds", 64'(rdata), 64'h55);
    rd_chk(8'h14, 32'hAA, "R9 new value after write");
    wr(8'h14, 0);
  endtask

  task automatic t_unmapped;
    rd_chk(8'h00, 0, "R8 baseline");
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h00, 0, "R8 misaligned write ignored");
    rd_chk(8'h20, 0, "R8 out of range read zero");
    wr(8'h04, 32'h77);
    rd_chk(8'h05, 0, "R8 misaligned read zero");
    rd_chk(8'h04, 32'h77, "R3 mapped after misaligned");
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_enable_rw;
    t_status;
    t_route;
    t_collide;
    t_rw_same;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule